// File: doc/BRIEF.md
# Glitch-Free Global Clock Source Selector

This block picks the signal that drives one global clock network from six candidates: two dedicated clock pins, two PLL counter outputs, one dual-purpose clock pin and one signal made by internal logic. A route setting chooses one of three paths. The first is the run-time group of the four clock-class inputs, where a two-bit select picks the member. The second is the dual-purpose pin. The third is the internal logic signal. A run-time enable turns the network off. A registered flag reports whether the committed source may serve as a PLL reference.

Every source has its own gate. A gate opens and closes only on the falling edge of its own source, so the output carries whole high phases. Two synchronizers form an interlock: a gate opens only after every other gate is seen closed. A control domain clocked by `clk` commits one request at a time. The next request is taken only when the gates, synchronized back into `clk`, match the committed choice.

Top module: `gclk_src_mux`

## Requirements
- R1: With route 00 and the enable high, `gclk_o` follows the dynamic source that `dyn_sel_i` names. The codes are 0 = dedicated pin 0, 1 = dedicated pin 1, 2 = PLL output 0 and 3 = PLL output 1.
- R2: With route 01 and the enable high, `gclk_o` follows `dp_pin_i`, and `dyn_sel_i` has no effect on the output.
- R3: With route 10 and the enable high, `gclk_o` follows `logic_src_i`, and `dyn_sel_i` has no effect on the output.
- R4: With route 11 (reserved), `gclk_o` stays low whatever the select and the enable are.
- R5: With `gclk_en_i` low, `gclk_o` stays low. Setting it high again brings back the selected source.
- R6: At most one gate is open at any time. Every high pulse on `gclk_o` is a complete high phase of one source, with no shortened pulse, including while the output switches or is gated.
- R7: While a change of source or enable is in progress, newer requests wait. The change in progress finishes and delivers the source it was heading for. Only then is the latest request committed.
- R8: `pll_ref_ok_o` is high when the committed route is 00 (a dedicated pin or a PLL output) and low for routes 01, 10 and 11, whatever the enable is.
- R9: While `rst` is high, `gclk_o` is low, `pll_ref_ok_o` is high and the committed choice is dedicated pin 0 with the output disabled.
- R10: When all sources toggle, a committed change completes within `BUSY_MAX` cycles of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for select, route and enable |
| rst | input | 1 | Synchronous active-high reset. It must be held for several periods of every source |
| dyn_clk_i | input | N_DYN | Clock-class sources: [0], [1] dedicated pins; [2], [3] PLL outputs |
| dp_pin_i | input | 1 | Dual-purpose clock pin source |
| logic_src_i | input | 1 | Internal logic source |
| dyn_sel_i | input | SEL_W | Run-time choice within the clock-class group |
| route_cfg_i | input | 2 | 00 dynamic group, 01 dual-purpose pin, 10 internal logic, 11 off |
| gclk_en_i | input | 1 | Run-time network enable |
| gclk_o | output | 1 | Global clock network drive |
| pll_ref_ok_o | output | 1 | Committed source may feed a PLL reference |

## Verification
The bench runs every combination of route, select and enable. Each of the six sources toggles at its own period, so the width of a high pulse shows which source produced it. Following the output sample by sample tells a correctly routed source from a wrong one, and from an output that should be held low. The reserved route, the disabled state and the select lines that have no effect are all checked this way. A quick pair of select changes shows whether the change in progress is finished before the newer request is taken. A pulse-width monitor that runs for the whole test finds any shortened or merged pulse during switching or gating.

// File: rtl/gclk_mux_pkg.sv
`timescale 1ns/1ps
package gclk_mux_pkg;
  typedef enum logic [1:0] {
    ROUTE_DYN   = 2'b00,
    ROUTE_DPIN  = 2'b01,
    ROUTE_LOGIC = 2'b10,
    ROUTE_OFF   = 2'b11
  } route_e;
endpackage

// File: rtl/gclk_gate_cell.sv
`timescale 1ns/1ps
// One source's gate: arming flops on the rising edge, gate flop on the falling edge.
module gclk_gate_cell #(
  parameter int ARM_STAGES = 1
) (
  input  logic src_clk,
  input  logic rst,
  input  logic want_i,
  input  logic others_on_i,
  output logic gate_o
);
  logic [ARM_STAGES-1:0] arm_q;
  logic                  gate_q;

  always_ff @(posedge src_clk) begin
    if (rst) begin
      arm_q <= '0;
    end else begin
      arm_q[0] <= want_i & ~others_on_i;
      for (int k = 1; k < ARM_STAGES; k++) arm_q[k] <= arm_q[k-1];
    end
  end

  always_ff @(negedge src_clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= arm_q[ARM_STAGES-1];
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/gclk_sel_ctrl.sv
`timescale 1ns/1ps
// Control domain: decodes route/select/enable, commits one change at a time.
module gclk_sel_ctrl
  import gclk_mux_pkg::*;
#(
  parameter int N_DYN    = 4,
  parameter int BUSY_MAX = 64,
  localparam int SEL_W   = $clog2(N_DYN),
  localparam int NSRC    = N_DYN + 2,
  localparam int IDX_W   = $clog2(NSRC + 1),
  localparam int CNT_W   = $clog2(BUSY_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] dyn_sel_i,
  input  logic [1:0]       route_cfg_i,
  input  logic             en_i,
  input  logic [NSRC-1:0]  gate_vec_i,
  output logic [NSRC-1:0]  want_o,
  output logic             pll_ok_o
);
  localparam logic [IDX_W-1:0] IDX_DP    = IDX_W'(N_DYN);
  localparam logic [IDX_W-1:0] IDX_LOGIC = IDX_W'(N_DYN + 1);
  localparam logic [IDX_W-1:0] IDX_NONE  = IDX_W'(NSRC);

  logic [NSRC-1:0]  gs1_q, gs2_q;
  logic [IDX_W-1:0] req_idx, cur_idx_q;
  logic             cur_on_q, pll_ok_q, busy;

  always_comb begin
    case (route_e'(route_cfg_i))
      ROUTE_DYN:   req_idx = IDX_W'(dyn_sel_i);
      ROUTE_DPIN:  req_idx = IDX_DP;
      ROUTE_LOGIC: req_idx = IDX_LOGIC;
      default:     req_idx = IDX_NONE;
    endcase
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_want
    assign want_o[g] = cur_on_q && (cur_idx_q == IDX_W'(g));
  end

  // A change is in flight until the returned gate state matches the commitment.
  assign busy = (gs2_q != want_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      gs1_q     <= '0;
      gs2_q     <= '0;
      cur_idx_q <= '0;
      cur_on_q  <= 1'b0;
      pll_ok_q  <= 1'b1;
    end else begin
      gs1_q <= gate_vec_i;
      gs2_q <= gs1_q;
      if (!busy) begin
        cur_idx_q <= req_idx;
        cur_on_q  <= en_i && (req_idx != IDX_NONE);
        pll_ok_q  <= (req_idx < IDX_DP);
      end
    end
  end

  assign pll_ok_o = pll_ok_q;

  // Checker-only run-length counter of an unfinished change.
  logic [CNT_W-1:0] busy_run_q;
  always_ff @(posedge clk) begin
    if (rst || !busy)                       busy_run_q <= '0;
    else if (busy_run_q != CNT_W'(BUSY_MAX)) busy_run_q <= busy_run_q + 1'b1;
  end

  assert_hold_commit_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cur_idx_q) && $stable(cur_on_q));

  assert_switch_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    busy_run_q < CNT_W'(BUSY_MAX));

  assert_flag_matches_gates_R8: assert property (@(posedge clk) disable iff (rst)
    (pll_ok_o && !busy) |-> (gs2_q[NSRC-1:N_DYN] == '0));
endmodule

// File: rtl/gclk_src_mux.sv
`timescale 1ns/1ps
module gclk_src_mux
  import gclk_mux_pkg::*;
#(
  parameter int N_DYN      = 4,
  parameter int ARM_STAGES = 1,
  parameter int BUSY_MAX   = 64,
  localparam int SEL_W     = $clog2(N_DYN),
  localparam int NSRC      = N_DYN + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DYN-1:0] dyn_clk_i,
  input  logic             dp_pin_i,
  input  logic             logic_src_i,
  input  logic [SEL_W-1:0] dyn_sel_i,
  input  logic [1:0]       route_cfg_i,
  input  logic             gclk_en_i,
  output logic             gclk_o,
  output logic             pll_ref_ok_o
);
  logic [NSRC-1:0] src_vec, want_vec, gate_vec, others_on;

  assign src_vec = {logic_src_i, dp_pin_i, dyn_clk_i};

  gclk_sel_ctrl #(.N_DYN(N_DYN), .BUSY_MAX(BUSY_MAX)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .dyn_sel_i   (dyn_sel_i),
    .route_cfg_i (route_cfg_i),
    .en_i        (gclk_en_i),
    .gate_vec_i  (gate_vec),
    .want_o      (want_vec),
    .pll_ok_o    (pll_ref_ok_o)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    assign others_on[g] = |(gate_vec & ~(NSRC'(1) << g));
    gclk_gate_cell #(.ARM_STAGES(ARM_STAGES)) u_cell (
      .src_clk     (src_vec[g]),
      .rst         (rst),
      .want_i      (want_vec[g]),
      .others_on_i (others_on[g]),
      .gate_o      (gate_vec[g])
    );
  end

  assign gclk_o = |(src_vec & gate_vec);

  assert_single_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_vec));
endmodule

// File: tb/gclk_src_mux_bench.sv
`timescale 1ns/1ps
module gclk_src_mux_bench;
  logic       clk = 1'b0, rst = 1'b1;
  logic [3:0] dyn_clk = '0;
  logic       dp_pin = 1'b0, logic_src = 1'b0;
  logic [1:0] dyn_sel = '0, route_cfg = '0;
  logic       gclk_en = 1'b0;
  logic       gclk_o, pll_ok;

  int checks = 0, errors = 0;
  int half_of [0:5] = '{7, 11, 5, 9, 13, 17};
  int cnt_w [0:31];
  int last_w = 0, bad_pulse = 0, pulses = 0;
  bit mon_on = 1'b0;
  realtime t_rise = 0.0;

  gclk_src_mux u_gclk_src_mux (
    .clk(clk), .rst(rst), .dyn_clk_i(dyn_clk), .dp_pin_i(dp_pin),
    .logic_src_i(logic_src), .dyn_sel_i(dyn_sel), .route_cfg_i(route_cfg),
    .gclk_en_i(gclk_en), .gclk_o(gclk_o), .pll_ref_ok_o(pll_ok)
  );

  always #10 clk = ~clk;
  always #7  dyn_clk[0] = ~dyn_clk[0];
  always #11 dyn_clk[1] = ~dyn_clk[1];
  always #5  dyn_clk[2] = ~dyn_clk[2];
  always #9  dyn_clk[3] = ~dyn_clk[3];
  always #13 dp_pin = ~dp_pin;
  always #17 logic_src = ~logic_src;

  // Pulse-width monitor: every high pulse must be one source's full high phase.
  always @(posedge gclk_o) t_rise = $realtime;
  always @(negedge gclk_o) begin
    if (mon_on && t_rise > 0.0) begin
      int w;
      bit legal;
      w = int'($realtime - t_rise);
      legal = 1'b0;
      for (int k = 0; k < 6; k++) if (w == half_of[k]) legal = 1'b1;
      if (!legal) bad_pulse++;
      if (w >= 0 && w < 32) cnt_w[w]++;
      last_w = w;
      pulses++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic src_level(input int idx);
    case (idx)
      0, 1, 2, 3: return dyn_clk[idx];
      4:          return dp_pin;
      5:          return logic_src;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic apply(input int cfg, input int sel, input bit en);
    @(negedge clk);
    route_cfg = 2'(cfg);
    dyn_sel   = 2'(sel);
    gclk_en   = en;
    repeat (40) @(negedge clk);
  endtask

  // Samples at half-ns offsets; all source edges fall on whole ns.
  task automatic follow(input int idx, input string req);
    int miss = 0;
    #0.5;
    for (int k = 0; k < 200; k++) begin
      if (gclk_o !== src_level(idx)) miss++;
      #1;
    end
    chk(miss == 0, req, "output follows expected source (mismatching samples)", miss, 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) cnt_w[k] = 0;
    repeat (12) @(negedge clk);
    #0.5;
    chk(gclk_o === 1'b0, "R9", "output low in reset", int'(gclk_o), 0);
    chk(pll_ok === 1'b1, "R9", "flag high in reset", int'(pll_ok), 1);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;
    repeat (20) @(negedge clk);
    follow(6, "R9 R5");   // default pin 0 but disabled: stays low

    // Exhaustive sweep over route, select and enable.
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int en = 0; en < 2; en++) begin
          int exp_idx;
          string req;
          apply(cfg, sel, en[0]);
          exp_idx = (cfg == 0) ? sel : (cfg == 1) ? 4 : (cfg == 2) ? 5 : 6;
          req = (cfg == 0) ? "R1 R10" : (cfg == 1) ? "R2" : (cfg == 2) ? "R3" : "R4";
          if (en == 0) begin
            exp_idx = 6;
            if (cfg != 3) req = "R5";
          end
          follow(exp_idx, req);
          if (exp_idx < 6)
            chk(last_w == half_of[exp_idx], req, "last pulse width", last_w, half_of[exp_idx]);
          chk(pll_ok === (cfg == 0), "R8", "PLL-reference flag", int'(pll_ok), int'(cfg == 0));
        end
      end
    end

    // R7: a newer request while a change is in flight waits for it to complete.
    apply(0, 0, 1'b1);
    for (int k = 0; k < 32; k++) cnt_w[k] = 0;
    @(negedge clk);
    dyn_sel = 2'd1;
    @(negedge clk);
    dyn_sel = 2'd3;
    repeat (40) @(negedge clk);
    chk(cnt_w[11] >= 2, "R7", "pin-1 pulses delivered before honouring newer select",
        cnt_w[11], 2);
    follow(3, "R7");

    // R5: re-enable after disable restores the source.
    apply(0, 2, 1'b0);
    follow(6, "R5");
    apply(0, 2, 1'b1);
    follow(2, "R5");

    chk(bad_pulse == 0, "R6", "shortened or merged high pulses", bad_pulse, 0);
    chk(pulses > 0, "R6", "high pulses observed", pulses, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule